// File: doc/BRIEF.md
# Cardiac Pacing Rate Guard with Ramp-Down Fallback

This block is the trusted hardware core of a rate-adaptive pacemaker. An untrusted rate-adaptive controller asks for pace pulses, one request strobe per chamber. The guard times each chamber from its last beat and passes a request to the pace output only when the resulting beat-to-beat interval is inside the programmed window. The window has two parts: a lower bound that sets the highest allowed rate, and an upper bound that sets the resting rate. It also holds the interval within a smoothing band around the previous interval. Sensed intrinsic beats restart the timing.

When a request is unsafe, or when the controller lets a chamber go unpaced past the resting interval, the guard blocks the controller. It raises a sticky violation flag and hands pacing to a built-in fallback. The fallback lengthens the interval by exactly the allowed smoothing step on each beat until it reaches the resting interval. Requests go on being judged while the fallback is in charge. After a programmed number of consecutive safe requests, control returns to the controller.

Rates are held as intervals in ticks of `tick_en`. The elapsed count E of a chamber is the number of ticks since its last beat. The beat cycle itself counts as one tick when `tick_en` is high. E is judged at the clock edge that samples a request, and a granted pace shows on `pace_o` one cycle later.

Top module: `pace_safety_core`

## Requirements
- R1: After reset, `pace_o` is 0, `src_fallback` is 0 (the controller is in charge) and `viol_o` is 0. No chamber has interval history.
- R2: While the controller is in charge, a request with E below `cfg_min_int` is blocked. `pace_o` stays 0, and `viol_o` and `src_fallback` are 1 in the next cycle. No pace is ever issued at E below `cfg_min_int`.
- R3: While the controller is in charge, a chamber whose E reaches `cfg_max_int` with no sense in that cycle gets a forced pace. `viol_o` and `src_fallback` are set as well.
- R4: While the controller is in charge, a request with history P whose E lies outside [P-step, P+step] is blocked, with the same effect as in R2. A request inside the band and inside [`cfg_min_int`, `cfg_max_int`] is paced one cycle later.
- R5: step is the sum of P>>(k+1) over each set bit k of `cfg_smooth`, so bit 0 adds a half, bit 1 a quarter, bit 2 an eighth and bit 3 a sixteenth of P. P is the E of the last beat, with 0 stored as 1. Without history there is no band check.
- R6: While the fallback is in charge, a chamber is paced when E reaches the target min(P+step, `cfg_max_int`), raised to `cfg_min_int` if it is lower. Without history the target is `cfg_max_int`. The interval therefore grows by one step per beat until it reaches the resting interval.
- R7: A sense restarts the timer of its chamber and records P. It never counts as a violation, whatever its timing. A request in the same cycle as a sense of that chamber is dropped: it gives no pace, no violation and no count.
- R8: While the fallback is in charge, requests never produce a pace.
- R9: While the fallback is in charge, `cfg_ret_cnt` consecutive safe requests (a value of 0 counts as 1) return control to the controller in the cycle after the last of them. An unsafe request restarts the count.
- R10: `viol_o` stays set until a `viol_clr` pulse clears it. A new violation in the same cycle as the clear wins.
- R11: The chambers are timed independently. Bit 0 of `sense_i`, `req_i` and `pace_o` is the atrium and bit 1 is the ventricle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Interval timebase tick |
| sense_i | input | NCH | Sensed intrinsic beat strobes |
| req_i | input | NCH | Pace requests from the untrusted controller |
| cfg_min_int | input | IW | Shortest allowed interval (highest rate) |
| cfg_max_int | input | IW | Resting interval (lowest rate) |
| cfg_smooth | input | SW | Smoothing fraction bits |
| cfg_ret_cnt | input | CW | Safe requests needed to return control |
| viol_clr | input | 1 | Clears the violation flag |
| pace_o | output | NCH | Pace pulses per chamber |
| src_fallback | output | 1 | 1 when the fallback is in charge |
| viol_o | output | 1 | Sticky violation flag |

## Verification
A table of requests is placed at and just beyond each edge of the smoothing band, for every single-bit fraction code and one two-bit code. It also probes the minimum-interval edge while the band would still allow the request, which separates a shift or sum error from a bound error. Directed sequences measure the spacing of fallback paces to show an exact per-beat ramp that stops at the resting interval. They time the forced pace after a restarting sense, and interleave safe and unsafe requests to separate a consecutive count from a total count. They also pit the clear pulse against a new violation and a sense against a same-cycle request.

// File: rtl/pace_pkg.sv
package pace_pkg;
  typedef enum logic {SRC_CTRL = 1'b0, SRC_FALLBACK = 1'b1} src_e;

  // per-chamber judgement of one cycle
  typedef struct packed {
    logic ok;    // request inside all bounds
    logic bad;   // request outside a bound
    logic late;  // controller left the chamber unpaced at the resting interval
  } chk_ev_t;
endpackage

// File: rtl/pace_chamber.sv
module pace_chamber
  import pace_pkg::*;
#(
  parameter int IW = 12,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          in_ctrl,
  input  logic          sense_i,
  input  logic          req_i,
  input  logic [IW-1:0] cfg_min,
  input  logic [IW-1:0] cfg_max,
  input  logic [SW-1:0] cfg_smooth,
  output chk_ev_t       ev_o,
  output logic          pace_o
);
  localparam logic [IW-1:0] ELAP_SAT = '1;
  localparam logic [IW-1:0] ONE      = IW'(1);

  logic [IW-1:0] elap_q, elap_d, prev_q, prev_d;
  logic          pace_q, pace_d;
  logic [IW:0]   step_w, lo_w, hi_w, tgt_w, elap_x;
  logic          has_hist, in_rng, band_ok, req_ok, fb_fire, late_w, deliver, beat;

  // smoothing step: sum of shifted copies of the previous interval
  always_comb begin
    step_w = '0;
    for (int k = 0; k < SW; k++) begin
      if (cfg_smooth[k]) step_w = step_w + (IW+1)'(prev_q >> (k + 1));
    end
  end

  always_comb begin
    elap_x   = {1'b0, elap_q};
    has_hist = (prev_q != '0);
    hi_w     = {1'b0, prev_q} + step_w;
    lo_w     = {1'b0, prev_q} - step_w;
    in_rng   = (elap_q >= cfg_min) && (elap_q <= cfg_max);
    band_ok  = !has_hist || ((elap_x >= lo_w) && (elap_x <= hi_w));
    req_ok   = in_rng && band_ok;
    // fallback target: one step longer, capped at rest, floored at the minimum
    if (!has_hist)                   tgt_w = {1'b0, cfg_max};
    else if (hi_w > {1'b0, cfg_max}) tgt_w = {1'b0, cfg_max};
    else                             tgt_w = hi_w;
    if (tgt_w < {1'b0, cfg_min})     tgt_w = {1'b0, cfg_min};
  end

  always_comb begin
    fb_fire  = !in_ctrl && (elap_x >= tgt_w);
    late_w   = in_ctrl && (elap_q >= cfg_max) && !(req_i && req_ok);
    deliver  = !sense_i && ((in_ctrl && req_i && req_ok) || fb_fire || late_w);
    beat     = sense_i || deliver;
    ev_o.ok   = !sense_i && req_i && req_ok;
    ev_o.bad  = !sense_i && req_i && !req_ok;
    ev_o.late = !sense_i && late_w;
  end

  // next state
  always_comb begin
    elap_d = elap_q;
    prev_d = prev_q;
    pace_d = deliver;
    if (beat) begin
      prev_d = (elap_q == '0) ? ONE : elap_q;
      elap_d = tick_en ? ONE : '0;
    end else if (tick_en && (elap_q != ELAP_SAT)) begin
      elap_d = elap_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elap_q <= '0;
      prev_q <= '0;
      pace_q <= 1'b0;
    end else begin
      elap_q <= elap_d;
      prev_q <= prev_d;
      pace_q <= pace_d;
    end
  end

  assign pace_o = pace_q;

  // R2: no pace is issued at an interval below the minimum
  p_pace_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pace_q |-> ($past(elap_q) >= $past(cfg_min)));

  // R3: controller silence up to the resting interval forces a pace
  p_late_pace_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ctrl && !sense_i && (elap_q >= cfg_max)) |=> pace_q);

  // R7: a sense restarts the timer and issues no pace
  p_sense_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sense_i |=> ((elap_q <= ONE) && !pace_q));

  // R8: in fallback, a request that is too early never paces
  p_fb_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ctrl && req_i && !sense_i && (elap_q < cfg_min)) |=> !pace_q);
endmodule

// File: rtl/pace_mode_ctrl.sv
module pace_mode_ctrl
  import pace_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  chk_ev_t       ev_i [NCH],
  input  logic          viol_clr,
  input  logic [CW-1:0] cfg_ret_cnt,
  output src_e          src_o,
  output logic          viol_o
);
  src_e        src_q, src_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic        viol_q, viol_d;
  logic        any_bad, any_ok;
  logic [CW:0] cnt_nx, ret_eff;

  always_comb begin
    any_bad = 1'b0;
    any_ok  = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      any_bad = any_bad | ev_i[c].bad | ev_i[c].late;
      any_ok  = any_ok  | ev_i[c].ok;
    end
  end

  always_comb begin
    cnt_nx  = {1'b0, cnt_q} + 1'b1;
    ret_eff = (cfg_ret_cnt == '0) ? (CW+1)'(1) : {1'b0, cfg_ret_cnt};
    src_d   = src_q;
    cnt_d   = cnt_q;
    if (any_bad) begin
      src_d = SRC_FALLBACK;
      cnt_d = '0;
    end else if ((src_q == SRC_FALLBACK) && any_ok) begin
      if (cnt_nx >= ret_eff) begin
        src_d = SRC_CTRL;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_nx[CW-1:0];
      end
    end
    viol_d = any_bad ? 1'b1 : (viol_clr ? 1'b0 : viol_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_CTRL;
      cnt_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      cnt_q  <= cnt_d;
      viol_q <= viol_d;
    end
  end

  assign src_o  = src_q;
  assign viol_o = viol_q;

  // R4: an unsafe request hands control to the fallback and flags it
  p_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|{ev_i[0].bad, ev_i[NCH-1].bad}) |=> ((src_q == SRC_FALLBACK) && viol_q));

  // R9: control only returns on a safe request
  p_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_q == SRC_CTRL) && ($past(src_q) == SRC_FALLBACK)) |-> $past(any_ok));

  // R10: the flag only drops after a clear request
  p_viol_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(viol_q) |-> $past(viol_clr));
endmodule

// File: rtl/pace_safety_core.sv
module pace_safety_core
  import pace_pkg::*;
#(
  parameter int IW  = 12,
  parameter int SW  = 4,
  parameter int CW  = 4,
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic [NCH-1:0] sense_i,
  input  logic [NCH-1:0] req_i,
  input  logic [IW-1:0]  cfg_min_int,
  input  logic [IW-1:0]  cfg_max_int,
  input  logic [SW-1:0]  cfg_smooth,
  input  logic [CW-1:0]  cfg_ret_cnt,
  input  logic           viol_clr,
  output logic [NCH-1:0] pace_o,
  output logic           src_fallback,
  output logic           viol_o
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  chk_ev_t    ev_w [NCH];
  src_e       src_w;
  logic       in_ctrl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign in_ctrl = (src_w == SRC_CTRL);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pace_chamber #(.IW(IW), .SW(SW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .tick_en    (tick_en),
      .in_ctrl    (in_ctrl),
      .sense_i    (sense_i[c]),
      .req_i      (req_i[c]),
      .cfg_min    (cfg_min_int),
      .cfg_max    (cfg_max_int),
      .cfg_smooth (cfg_smooth),
      .ev_o       (ev_w[c]),
      .pace_o     (pace_o[c])
    );
  end

  pace_mode_ctrl #(.NCH(NCH), .CW(CW)) u_mode (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .ev_i        (ev_w),
    .viol_clr    (viol_clr),
    .cfg_ret_cnt (cfg_ret_cnt),
    .src_o       (src_w),
    .viol_o      (viol_o)
  );

  assign src_fallback = (src_w == SRC_FALLBACK);

  // R1: nothing paces while the core is held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_core_n |=> (pace_o == '0));
endmodule

// File: tb/sim_pace_safety_core.sv
module sim_pace_safety_core;
  logic       clk = 1'b0;
  logic       rst_n, tick_en, viol_clr;
  logic [1:0] sense_i, req_i;
  logic [11:0] cfg_min_int, cfg_max_int;
  logic [3:0] cfg_smooth, cfg_ret_cnt;
  logic [1:0] pace_o;
  logic       src_fallback, viol_o;
  int         nchk = 0, nerr = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  pace_safety_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sense_i(sense_i), .req_i(req_i),
    .cfg_min_int(cfg_min_int), .cfg_max_int(cfg_max_int), .cfg_smooth(cfg_smooth),
    .cfg_ret_cnt(cfg_ret_cnt), .viol_clr(viol_clr), .pace_o(pace_o),
    .src_fallback(src_fallback), .viol_o(viol_o)
  );

  // {chamber, smooth code, prev interval A, request at E=B, expect paced}
  localparam logic [21:0] VEC [17] = '{
    {1'b1, 4'b0010, 8'd40, 8'd40, 1'b1},
    {1'b0, 4'b0010, 8'd40, 8'd50, 1'b1},
    {1'b1, 4'b0010, 8'd40, 8'd51, 1'b0},
    {1'b0, 4'b0010, 8'd40, 8'd30, 1'b1},
    {1'b1, 4'b0010, 8'd40, 8'd29, 1'b0},
    {1'b1, 4'b0001, 8'd40, 8'd60, 1'b1},
    {1'b0, 4'b0001, 8'd40, 8'd61, 1'b0},
    {1'b1, 4'b0100, 8'd40, 8'd45, 1'b1},
    {1'b0, 4'b0100, 8'd40, 8'd46, 1'b0},
    {1'b1, 4'b1000, 8'd40, 8'd38, 1'b1},
    {1'b0, 4'b1000, 8'd40, 8'd37, 1'b0},
    {1'b1, 4'b0011, 8'd40, 8'd70, 1'b1},
    {1'b0, 4'b0011, 8'd40, 8'd71, 1'b0},
    {1'b1, 4'b0001, 8'd12, 8'd9,  1'b0},
    {1'b0, 4'b0001, 8'd12, 8'd10, 1'b1},
    {1'b1, 4'b0000, 8'd40, 8'd41, 1'b0},
    {1'b0, 4'b0000, 8'd40, 8'd40, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int mn, input int mx, input int sm, input int rc);
    @(negedge clk);
    tick_en = 1'b0; sense_i = '0; req_i = '0; viol_clr = 1'b0;
    rst_n = 1'b0;
    cfg_min_int = 12'(mn); cfg_max_int = 12'(mx);
    cfg_smooth = 4'(sm); cfg_ret_cnt = 4'(rc);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b1;
  endtask

  // drive strobes so they are sampled at the e-th rising edge from now
  task automatic fire(input logic [1:0] s, input logic [1:0] r, input logic c, input int e);
    repeat (e - 1) @(negedge clk);
    sense_i = s; req_i = r; viol_clr = c;
    @(negedge clk);
    sense_i = '0; req_i = '0; viol_clr = 1'b0;
  endtask

  task automatic wait_vpace(output int n);
    n = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      n++;
      if (pace_o[1]) break;
    end
  endtask

  initial begin
    int gap;
    rst_n = 1'b0; tick_en = 1'b0; sense_i = '0; req_i = '0; viol_clr = 1'b0;
    cfg_min_int = 12'd10; cfg_max_int = 12'd120; cfg_smooth = '0; cfg_ret_cnt = 4'd3;

    // R1: reset state
    do_reset(10, 120, 0, 3);
    check("R1 pace after reset", pace_o, 0);
    check("R1 source after reset", src_fallback, 0);
    check("R1 flag after reset", viol_o, 0);

    // table: band edges (R4, R5), minimum interval (R2), chamber separation (R11)
    for (int i = 0; i < 17; i++) begin
      logic [21:0] v;
      logic [1:0]  m;
      v = VEC[i];
      m = v[21] ? 2'b10 : 2'b01;
      do_reset(10, 120, int'(v[20:17]), 3);
      fire(2'b11, 2'b00, 1'b0, 1);
      fire(2'b11, 2'b00, 1'b0, int'(v[16:9]));
      fire(2'b00, m, 1'b0, int'(v[8:1]));
      check($sformatf("R4 R5 R2 vec %0d pace", i), int'(pace_o & m), v[0] ? int'(m) : 0);
      check($sformatf("R11 vec %0d other chamber quiet", i), int'(pace_o & ~m), 0);
      check($sformatf("R4 vec %0d flag", i), viol_o, v[0] ? 0 : 1);
      check($sformatf("R4 vec %0d source", i), src_fallback, v[0] ? 0 : 1);
    end

    // R7: sense with a same-cycle request drops the request, restarts timing
    do_reset(10, 120, 2, 3);
    fire(2'b11, 2'b00, 1'b0, 1);
    fire(2'b11, 2'b10, 1'b0, 40);
    check("R7 same-cycle request dropped", pace_o, 0);
    check("R7 same-cycle no violation", viol_o, 0);
    fire(2'b00, 2'b10, 1'b0, 40);
    check("R7 timer restarted by sense", pace_o, 2'b10);

    // R3 + R7: early sense is harmless; forced pace at resting interval after last sense
    do_reset(10, 100, 0, 3);
    fire(2'b11, 2'b00, 1'b0, 1);
    fire(2'b11, 2'b00, 1'b0, 5);
    check("R7 early sense no violation", viol_o, 0);
    fire(2'b11, 2'b00, 1'b0, 60);
    begin
      logic [1:0] seen;
      seen = '0;
      for (int k = 0; k < 99; k++) begin
        @(negedge clk);
        seen = seen | pace_o;
      end
      check("R3 no pace before resting interval", seen, 0);
    end
    @(negedge clk);
    check("R3 forced pace at resting interval", pace_o, 2'b11);
    check("R3 forced pace flags violation", viol_o, 1);
    check("R3 forced pace hands over", src_fallback, 1);

    // R10: sticky flag, clear, and set beating clear
    fire(2'b00, 2'b00, 1'b0, 10);
    check("R10 flag held", viol_o, 1);
    fire(2'b00, 2'b00, 1'b1, 1);
    check("R10 flag cleared", viol_o, 0);
    fire(2'b00, 2'b01, 1'b1, 5);
    check("R10 set wins over clear", viol_o, 1);
    check("R8 early request in fallback blocked", pace_o, 0);

    // R6: fallback ramp, one quarter step per beat up to rest
    do_reset(10, 100, 2, 3);
    fire(2'b11, 2'b00, 1'b0, 1);
    fire(2'b11, 2'b00, 1'b0, 40);
    fire(2'b00, 2'b10, 1'b0, 25);
    check("R4 short request blocked", pace_o, 0);
    check("R4 short request trips", src_fallback, 1);
    wait_vpace(gap); check("R6 first fallback beat", gap, 25);
    wait_vpace(gap); check("R6 ramp beat 2", gap, 62);
    wait_vpace(gap); check("R6 ramp beat 3", gap, 77);
    wait_vpace(gap); check("R6 ramp beat 4", gap, 96);
    wait_vpace(gap); check("R6 ramp capped at rest", gap, 100);

    // R8 + R9: safe requests counted, not paced; unsafe restarts the count
    fire(2'b00, 2'b10, 1'b0, 80);
    check("R8 safe request in fallback not paced", pace_o, 0);
    check("R9 one safe request", src_fallback, 1);
    wait_vpace(gap);
    fire(2'b00, 2'b10, 1'b0, 80);
    check("R9 two safe requests", src_fallback, 1);
    wait_vpace(gap);
    fire(2'b00, 2'b10, 1'b0, 20);
    check("R9 unsafe request keeps fallback", src_fallback, 1);
    wait_vpace(gap);
    fire(2'b00, 2'b10, 1'b0, 80);
    wait_vpace(gap);
    fire(2'b00, 2'b10, 1'b0, 80);
    check("R9 count restarted after unsafe", src_fallback, 1);
    wait_vpace(gap);
    fire(2'b00, 2'b10, 1'b0, 80);
    check("R9 control returned", src_fallback, 0);
    check("R8 returning request not paced", pace_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule